// File: doc/BRIEF.md
# BF16 Block Fixed-Point Aligner

This block turns bfloat16 activations into fixed point that shares one exponent per block. On every clock it can take one beat of sixteen BF16 values. Beats are paired in the order they are accepted, so two beats form a 32-element block. The block finds the largest biased exponent among all 32 elements. It then shifts each element's mantissa right by the distance between that block exponent and the element's own exponent. The result leaves as sixteen 27-bit two's-complement numbers per output beat.

The first beat of a block waits in a holding register until its partner arrives. Once the pair is complete, the two aligned beats leave on two consecutive cycles, first beat first. Back-to-back blocks therefore stream without gaps. NaN and infinity encodings get no special handling: an exponent of 255 is just the largest possible exponent.

Top module: `bf16_block_aligner`

## Requirements
- R1: Input lane i occupies `in_data[16i+15:16i]`, with the sign in bit 15, the biased exponent in bits 14:7 and the fraction in bits 6:0. Output lane i occupies `out_data[27i+26:27i]` and belongs to the input lane with the same index.
- R2: The block exponent is the largest exponent of all 32 elements of a block. Each element's 26-bit magnitude has the hidden one at bit 25 and the fraction at bits 24:18. That magnitude is shifted right by the block exponent minus the element's exponent.
- R3: An element whose exponent field is zero yields an output of zero, whatever its sign and fraction.
- R4: When the shift distance is 26 or more, the output is zero.
- R5: An element with its sign bit set yields the 27-bit two's-complement negation of its shifted magnitude. A positive element never sets output bit 26.
- R6: The first beat of a block is held unchanged while `in_valid` is low, for any number of cycles, and `in_data` is ignored on those cycles.
- R7: When the second beat of a block is accepted in cycle t, `out_valid` is high in cycles t+2 and t+3. The output carries the aligned first beat in t+2 and the aligned second beat in t+3. `out_valid` is low in all other cycles.
- R8: A beat can be accepted on every clock. Back-to-back blocks give an unbroken output stream in which each beat appears three cycles after it was accepted.
- R9: While `rst_n` is low, `out_valid` and `out_data` are zero. After reset, the next accepted beat starts a new block, and any half-collected block is dropped.
- R10: An exponent of 255 is treated as an ordinary exponent, both in the block maximum and in the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat present on `in_data` this cycle |
| in_data | input | 256 | Sixteen BF16 elements |
| out_valid | output | 1 | Aligned beat present on `out_data` |
| out_data | output | 432 | Sixteen 27-bit two's-complement fixed-point values |

## Verification
The functions most likely to collide are these two. First, the hold register takes the first beat of the next block. Second, in the same cycle, the previous block's pair is being aligned and driven out. At the same time the final stage switches its source from the pair register to the tail register. The bench provokes this by sending block after block with no idle cycles, including a sweep of every exponent gap from 0 to 30. It judges the result by comparing each output beat, in order, against values it computes arithmetically. It also checks `out_valid` in every cycle against the schedule it predicts from the cycles in which second beats were sent.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  localparam int BF_W   = 16;
  localparam int FRAC_W = 7;
  localparam int EXP_W  = BF_W - FRAC_W - 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int MAG_W  = 26;
  localparam int FIX_W  = MAG_W + 1;
  localparam int PAD_W  = MAG_W - SIG_W;

  typedef logic [EXP_W-1:0] exp_t;
  typedef logic [MAG_W-1:0] mag_t;
  typedef logic [FIX_W-1:0] fix_t;

  // biased exponent field of one element
  function automatic exp_t bf_exp(input logic [BF_W-1:0] v);
    return v[BF_W-2:FRAC_W];
  endfunction

  // hidden one plus fraction, left-justified in the magnitude; zero exponent gives zero
  function automatic mag_t bf_mag(input logic [BF_W-1:0] v);
    if (v[BF_W-2:FRAC_W] == '0) return '0;
    return {1'b1, v[FRAC_W-1:0], {PAD_W{1'b0}}};
  endfunction

  // right shift that saturates to zero at or beyond the magnitude width
  function automatic mag_t bf_shift(input mag_t m, input exp_t amt);
    if (int'(amt) >= MAG_W) return '0;
    return m >> amt;
  endfunction

  // apply the sign as a two's-complement negation
  function automatic fix_t bf_sign(input mag_t m, input logic neg);
    fix_t wide;
    wide = {1'b0, m};
    return neg ? (~wide + fix_t'(1)) : wide;
  endfunction
endpackage

// File: rtl/bfa_exp_max.sv
module bfa_exp_max
  import bfa_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [LANES*BF_W-1:0] beat,
  output exp_t                  max_exp
);
  exp_t lane_exp [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_field
    assign lane_exp[g] = bf_exp(beat[g*BF_W +: BF_W]);
  end

  always_comb begin
    max_exp = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_exp[i] > max_exp) max_exp = lane_exp[i];
    end
  end
endmodule

// File: rtl/bfa_lane_align.sv
module bfa_lane_align
  import bfa_pkg::*;
(
  input  logic [BF_W-1:0] elem,
  input  exp_t            block_exp,
  input  logic            live,
  output fix_t            fixed
);
  exp_t elem_exp;
  exp_t gap;
  mag_t mag;
  mag_t shifted;

  always_comb begin
    elem_exp = bf_exp(elem);
    gap      = block_exp - elem_exp;
    mag      = bf_mag(elem);
    shifted  = bf_shift(mag, gap);
    fixed    = bf_sign(shifted, elem[BF_W-1]);
  end

  // the block exponent arrives from a separate max unit and must dominate
  always_comb begin
    if (live) begin
      assert_max_dominates_R2: assert (block_exp >= elem_exp)
        else $error("block exponent below element exponent");
      assert_no_overflow_R5: assert (elem[BF_W-1] || !fixed[FIX_W-1])
        else $error("positive element reached the sign bit");
      assert_zero_exp_R3: assert (elem_exp != '0 || fixed == '0)
        else $error("zero-exponent element produced nonzero output");
    end
  end
endmodule

// File: rtl/bf16_block_aligner.sv
module bf16_block_aligner
  import bfa_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*BF_W-1:0]   in_data,
  output logic                    out_valid,
  output logic [LANES*FIX_W-1:0]  out_data
);
  localparam int BEAT_W = LANES * BF_W;
  localparam int OUT_W  = LANES * FIX_W;

  // pairing state: high once the first beat of a block is held
  logic              second_due;
  logic              take_first;
  logic              take_second;

  // stage 1: hold register for the first beat
  logic [BEAT_W-1:0] hold_beat;
  exp_t              hold_exp;

  // stage 2: completed pair, then the delayed second beat
  logic              pair_vld;
  logic [BEAT_W-1:0] pair_first;
  logic [BEAT_W-1:0] pair_second;
  exp_t              pair_exp;
  logic              tail_vld;
  logic [BEAT_W-1:0] tail_beat;
  exp_t              tail_exp;

  exp_t              in_exp;
  exp_t              block_exp;
  logic              sel_vld;
  logic [BEAT_W-1:0] sel_beat;
  exp_t              sel_exp;
  logic [OUT_W-1:0]  aligned;

  assign take_first  = in_valid && !second_due;
  assign take_second = in_valid &&  second_due;

  bfa_exp_max #(.LANES(LANES)) u_in_max (
    .beat    (in_data),
    .max_exp (in_exp)
  );

  assign block_exp = (hold_exp > in_exp) ? hold_exp : in_exp;

  // the pair register has priority: pair and tail are never valid together
  assign sel_vld  = pair_vld || tail_vld;
  assign sel_beat = pair_vld ? pair_first : tail_beat;
  assign sel_exp  = pair_vld ? pair_exp   : tail_exp;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bfa_lane_align u_lane (
      .elem      (sel_beat[g*BF_W +: BF_W]),
      .block_exp (sel_exp),
      .live      (sel_vld),
      .fixed     (aligned[g*FIX_W +: FIX_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_due  <= 1'b0;
      hold_beat   <= '0;
      hold_exp    <= '0;
      pair_vld    <= 1'b0;
      pair_first  <= '0;
      pair_second <= '0;
      pair_exp    <= '0;
      tail_vld    <= 1'b0;
      tail_beat   <= '0;
      tail_exp    <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
    end else begin
      if (in_valid) second_due <= !second_due;
      if (take_first) begin
        hold_beat <= in_data;
        hold_exp  <= in_exp;
      end
      pair_vld <= take_second;
      if (take_second) begin
        pair_first  <= hold_beat;
        pair_second <= in_data;
        pair_exp    <= block_exp;
      end
      tail_vld <= pair_vld;
      if (pair_vld) begin
        tail_beat <= pair_second;
        tail_exp  <= pair_exp;
      end
      out_valid <= sel_vld;
      if (sel_vld) out_data <= aligned;
    end
  end

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (second_due && !in_valid) |=> $stable(hold_beat))
    else $error("held first beat changed while idle");

  assert_pair_emitted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_second |-> ##2 out_valid ##1 out_valid)
    else $error("completed block not emitted on two consecutive cycles");

  assert_stage_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pair_vld && tail_vld))
    else $error("pair and tail stages valid together");

  assert_reset_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid)
    else $error("output valid right after reset");
endmodule

// File: tb/bf16_block_aligner_tb.sv
module bf16_block_aligner_tb;
  localparam int LANES  = 16;
  localparam int BW     = 16;
  localparam int FW     = 27;
  localparam int BEAT_W = LANES * BW;
  localparam int OUT_W  = LANES * FW;
  localparam int QD     = 512;
  localparam int VM     = 8192;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [BEAT_W-1:0] in_data = '0;
  logic              out_valid;
  logic [OUT_W-1:0]  out_data;

  bf16_block_aligner #(.LANES(LANES)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  logic [OUT_W-1:0] exp_q [QD];
  string            tag_q [QD];
  int  wr_i = 0;
  int  rd_i = 0;
  bit  vmask [VM];
  bit  fin = 1'b0;
  bit  mon_on = 1'b0;
  int unsigned seed = 32'h1234_5678;

  function automatic logic [15:0] mk(input int s, input int e, input int f);
    logic [15:0] v;
    v[15]   = s[0];
    v[14:7] = e[7:0];
    v[6:0]  = f[6:0];
    return v;
  endfunction

  // expected value from the arithmetic: (1.f) * 2^25 / 2^(bmax-e)
  function automatic logic [FW-1:0] ref_elem(input logic [15:0] v, input int bmax);
    int e;
    int d;
    longint m;
    longint p;
    e = int'(v[14:7]);
    if (e == 0) return '0;
    d = bmax - e;
    if (d >= 26) return '0;
    p = 1;
    for (int k = 0; k < d; k++) p = p * 2;
    m = (longint'(128 + int'(v[6:0])) * 262144) / p;
    if (v[15]) m = 0 - m;
    return m[FW-1:0];
  endfunction

  function automatic int block_max(input logic [BEAT_W-1:0] a, input logic [BEAT_W-1:0] b);
    int mx;
    mx = 0;
    for (int i = 0; i < LANES; i++) begin
      if (int'(a[i*BW+7 +: 8]) > mx) mx = int'(a[i*BW+7 +: 8]);
      if (int'(b[i*BW+7 +: 8]) > mx) mx = int'(b[i*BW+7 +: 8]);
    end
    return mx;
  endfunction

  function automatic logic [OUT_W-1:0] ref_beat(input logic [BEAT_W-1:0] x, input int bmax);
    logic [OUT_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*FW +: FW] = ref_elem(x[i*BW +: BW], bmax);
    return r;
  endfunction

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0b expected=%0b", req, cyc, act, expv);
    end
  endtask

  // leaves in_valid high on the second beat so blocks can run back to back
  task automatic send_block(input logic [BEAT_W-1:0] a, input logic [BEAT_W-1:0] b,
                            input int gap, input string tag);
    int bm;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = a;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = ~a;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    bm = block_max(a, b);
    exp_q[wr_i % QD] = ref_beat(a, bm);
    tag_q[wr_i % QD] = tag;
    exp_q[(wr_i + 1) % QD] = ref_beat(b, bm);
    tag_q[(wr_i + 1) % QD] = tag;
    wr_i = wr_i + 2;
    vmask[(cyc + 2) % VM] = 1'b1;
    vmask[(cyc + 3) % VM] = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // R7 schedule and in-order data check on every cycle
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      check_bit("R7", out_valid, vmask[cyc % VM]);
      vmask[cyc % VM] = 1'b0;
      if (out_valid) begin
        checks++;
        if (out_data !== exp_q[rd_i % QD]) begin
          errors++;
          $display("FAIL %s beat=%0d actual=%h expected=%h", tag_q[rd_i % QD], rd_i,
                   out_data, exp_q[rd_i % QD]);
        end
        rd_i++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [BEAT_W-1:0] a;
    logic [BEAT_W-1:0] b;
    repeat (3) @(negedge clk);
    // R9: reset state
    check_bit("R9", out_valid, 1'b0);
    checks++;
    if (out_data !== '0) begin
      errors++;
      $display("FAIL R9 out_data actual=%h expected=0", out_data);
    end
    rst_n  = 1'b1;
    mon_on = 1'b1;

    // R2/R4: sweep every gap 0..30, maximum alternating between the beats, back to back (R8)
    for (int d = 0; d <= 30; d++) begin
      for (int i = 0; i < LANES; i++) begin
        a[i*BW +: BW] = mk(i % 2, 200 - d, i * 7 + d);
        b[i*BW +: BW] = mk((i + 1) % 2, 200 - d, i * 5 + 3);
      end
      if (d % 2 == 0) b[15*BW +: BW] = mk(0, 200, d * 3);
      else            a[3*BW +: BW]  = mk(1, 200, d * 3);
      send_block(a, b, 0, (d >= 26) ? "R4" : "R2");
    end
    idle(3);

    // R3: zero exponents with sign and fraction set
    for (int i = 0; i < LANES; i++) begin
      a[i*BW +: BW] = (i % 2 == 0) ? mk(1, 0, 127 - i) : mk(i % 3, 10, i);
      b[i*BW +: BW] = mk(i % 2, 0, i * 9);
    end
    send_block(a, b, 1, "R3");
    idle(2);

    // R5: all negative, exponents spread
    for (int i = 0; i < LANES; i++) begin
      a[i*BW +: BW] = mk(1, 120 + i, i * 11);
      b[i*BW +: BW] = mk(1, 128 - i, 127 - i * 3);
    end
    send_block(a, b, 0, "R5");
    idle(2);

    // R10: exponent 255 treated as ordinary
    for (int i = 0; i < LANES; i++) begin
      a[i*BW +: BW] = mk(i % 2, 255 - i, i * 13);
      b[i*BW +: BW] = mk(0, 240 + i, 64 + i);
    end
    send_block(a, b, 0, "R10");
    idle(2);

    // R1: each lane a distinct exponent and fraction so a misplaced lane shows
    for (int i = 0; i < LANES; i++) begin
      a[i*BW +: BW] = mk(i % 2, 100 + i, i * 8 + 1);
      b[i*BW +: BW] = mk((i / 2) % 2, 90 + i * 2, 127 - i * 8);
    end
    send_block(a, b, 0, "R1");
    idle(2);

    // R6: first beat held across idle cycles with garbage on the input
    for (int i = 0; i < LANES; i++) begin
      a[i*BW +: BW] = mk(i % 2, 60 + i, i * 6);
      b[i*BW +: BW] = mk(0, 55 + i, i * 4 + 2);
    end
    send_block(a, b, 5, "R6");
    idle(4);

    // R9: reset drops a half-collected block, pairing restarts
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = {LANES{mk(0, 150, 5)}};
    idle(2);
    rst_n = 1'b0;
    @(negedge clk);
    check_bit("R9", out_valid, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      a[i*BW +: BW] = mk(0, 70 + i, i);
      b[i*BW +: BW] = mk(1, 80 - i, i * 2);
    end
    send_block(a, b, 0, "R9");
    idle(3);

    // R8: long back-to-back run of pseudo-random blocks
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < LANES; i++) begin
        int unsigned r1;
        int unsigned r2;
        r1 = rnd();
        r2 = rnd();
        a[i*BW +: BW] = mk(int'(r1 % 2), 90 + int'((r1 >> 3) % 40), int'(r1 >> 9));
        b[i*BW +: BW] = mk(int'(r2 % 2), 90 + int'((r2 >> 3) % 40), int'(r2 >> 9));
      end
      send_block(a, b, 0, "R8");
    end
    idle(8);

    // R7: every expected beat came out
    checks++;
    if (rd_i != wr_i) begin
      errors++;
      $display("FAIL R7 beats actual=%0d expected=%0d", rd_i, wr_i);
    end
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule